// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is an I2C target that sits in front of an external byte-wide memory of 8,192 locations and serves reads from it. SCL and SDA arrive as synchronised inputs, and the block pulls SDA low through a single drive enable. It recognises START, repeated START and STOP. It answers one 7-bit device address and keeps a 13-bit address counter that survives from one transaction to the next. The memory port is synchronous: a read strobe returns data on the following clock, and a write strobe stores data on the clock edge where it is sampled.

A master can read in three ways. A current-address read continues from wherever the counter stands. A random read first sends a dummy write, which is the device address, a high and a low address byte and no data, and then a repeated START with the read bit set. A sequential read is either of these carried on: the master acknowledges each byte and stops with a not-acknowledge. A single data byte after the two address bytes stores one byte so the memory can be loaded.

The states are IDLE, DEV (device address shifts in), DEV_ACK, HI (high address byte), HI_ACK, LO (low address byte), LO_ACK, WDAT (write data), WR_ACK, TX (data byte shifts out), MACK (master acknowledge slot) and SKIP (bus ignored). The transitions are:
- START goes from any state to DEV.
- STOP goes from any state to IDLE.
- In DEV, a matching byte goes to DEV_ACK. A mismatch goes to SKIP.
- DEV_ACK goes to TX when the read bit is set and to HI when it is clear.
- HI goes to HI_ACK, then LO.
- LO goes to LO_ACK, then WDAT.
- WDAT goes to WR_ACK, then back to WDAT.
- TX goes to MACK.
- In MACK, an ACK goes back to TX and a NOACK goes to SKIP.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, SDA is released, neither memory strobe is active and the address counter is 0, so the first current-address read returns the byte at address 0.
- R2: A STOP (SDA rising while SCL is high) releases SDA and abandons any transaction in progress. A START (SDA falling while SCL is high) begins a new device-address byte from any state.
- R3: The device address is bits 7..1 of the first byte and R/W is bit 0, with 1 meaning read. On a match the block pulls SDA low for the ninth clock. On a mismatch it never drives SDA until the next START.
- R4: A write-mode address phase acknowledges the high and the low address byte and loads the counter with {high[4:0], low}. It writes no memory location, and a STOP before the low byte completes leaves the counter unchanged.
- R5: Bits 7..5 of the high address byte have no effect on the loaded address.
- R6: After an address phase, a repeated START with the read bit set returns the byte at the loaded address.
- R7: The counter always holds one more than the last address read or written, so a current-address read after an access to N returns the byte at N+1.
- R8: An ACK from the master after a data byte brings the byte at the next address. A NOACK followed by STOP ends the read with SDA released.
- R9: The counter wraps from 8191 to 0, and reading continues across the wrap with valid data.
- R10: A data byte after the two address bytes is stored at the loaded address and acknowledged, and the counter then advances by one.
- R11: The block changes its SDA drive only while SCL is low, and it sends data most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_addr | output | 13 | Memory address |
| mem_re | output | 1 | Read strobe; data returns on the following clock |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |

## Verification
A master acknowledge does two things in one cycle: it issues the memory fetch and it increments the address counter. The fetch must use the address before the increment. The bench provokes this at the top of the array with a random read at 8190 that streams four bytes, so the increment and the wrap to zero fall on the fetch cycle. The bench judges the result by comparing every byte against a behavioural model that keeps its own counter and memory image. A per-clock monitor separately checks that SDA drive never changes while SCL is high.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_WDAT,
        ST_WR_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } slv_state_t;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff[0] <= scl_i;
                    sda_ff[0] <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rx,
    input  logic          rx_bit,
    input  logic          tx,
    input  logic          tick,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    output logic [W-1:0]  data,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else begin
            if (load)    data <= load_val;
            else if (rx) data <= {data[W-2:0], rx_bit};
            else if (tx) data <= {data[W-2:0], 1'b0};
            if (clr)             cnt <= '0;
            else if (rx || tick) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ctr
);
    always_ff @(posedge clk) begin
        if (!rst_n)    ctr <= '0;
        else if (load) ctr <= load_val;
        else if (inc)  ctr <= ctr + 1'b1;
    end

    // R9: one step per increment, top address folds back to zero
    a_r9_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (ctr == (($past(ctr) == {AW{1'b1}}) ? '0 : $past(ctr) + 1'b1)));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2cm_pkg::*;
#(
    parameter int          MEM_BYTES   = 8192,
    parameter logic [6:0]  DEV_ADDR    = 7'h50,
    parameter int          SYNC_STAGES = 2,
    localparam int         AW          = $clog2(MEM_BYTES),
    localparam int         HI_BITS     = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    slv_state_t st, st_n;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0] sh_data;
    logic [3:0] sh_cnt;
    logic       sh_clr, sh_rx, sh_tx, sh_tick;
    logic [AW-1:0] ctr;
    logic       ctr_load, ctr_inc;
    logic [7:0] hi_q;
    logic       rd_mode, re_d;
    logic       oe_n, rd_req, wr_req, hi_cap, mode_cap;
    logic       byte_done;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2cm_shreg #(.W(8)) u_sh (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .rx(sh_rx), .rx_bit(sda_s),
        .tx(sh_tx), .tick(sh_tick), .load(re_d), .load_val(mem_rdata),
        .data(sh_data), .cnt(sh_cnt)
    );

    i2cm_addr_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load),
        .load_val({hi_q[HI_BITS-1:0], sh_data}), .inc(ctr_inc), .ctr(ctr)
    );

    assign byte_done = scl_fall && (sh_cnt == 4'd8);

    // next state and control decode
    always_comb begin
        st_n     = st;
        oe_n     = sda_oe;
        sh_clr   = 1'b0;
        sh_rx    = 1'b0;
        sh_tx    = 1'b0;
        sh_tick  = 1'b0;
        ctr_load = 1'b0;
        ctr_inc  = 1'b0;
        rd_req   = 1'b0;
        wr_req   = 1'b0;
        hi_cap   = 1'b0;
        mode_cap = 1'b0;
        if (stop_p) begin
            st_n = ST_IDLE;
            oe_n = 1'b0;
        end else if (start_p) begin
            st_n   = ST_DEV;
            oe_n   = 1'b0;
            sh_clr = 1'b1;
        end else begin
            unique case (st)
                ST_DEV: begin
                    if (scl_rise) sh_rx = 1'b1;
                    else if (byte_done) begin
                        sh_clr = 1'b1;
                        if (sh_data[7:1] == DEV_ADDR) begin
                            oe_n     = 1'b1;
                            st_n     = ST_DEV_ACK;
                            mode_cap = 1'b1;
                            if (sh_data[0]) begin
                                rd_req  = 1'b1;
                                ctr_inc = 1'b1;
                            end
                        end else begin
                            st_n = ST_SKIP;
                        end
                    end
                end
                ST_HI: begin
                    if (scl_rise) sh_rx = 1'b1;
                    else if (byte_done) begin
                        sh_clr = 1'b1;
                        hi_cap = 1'b1;
                        oe_n   = 1'b1;
                        st_n   = ST_HI_ACK;
                    end
                end
                ST_LO: begin
                    if (scl_rise) sh_rx = 1'b1;
                    else if (byte_done) begin
                        sh_clr   = 1'b1;
                        ctr_load = 1'b1;
                        oe_n     = 1'b1;
                        st_n     = ST_LO_ACK;
                    end
                end
                ST_WDAT: begin
                    if (scl_rise) sh_rx = 1'b1;
                    else if (byte_done) begin
                        sh_clr  = 1'b1;
                        wr_req  = 1'b1;
                        ctr_inc = 1'b1;
                        oe_n    = 1'b1;
                        st_n    = ST_WR_ACK;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rd_mode) begin
                            st_n = ST_TX;
                            oe_n = ~sh_data[7];
                        end else begin
                            st_n = ST_HI;
                            oe_n = 1'b0;
                        end
                    end
                end
                ST_HI_ACK: begin
                    if (scl_fall) begin
                        st_n = ST_LO;
                        oe_n = 1'b0;
                    end
                end
                ST_LO_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        st_n = ST_WDAT;
                        oe_n = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) sh_tick = 1'b1;
                    else if (scl_fall) begin
                        if (sh_cnt == 4'd8) begin
                            sh_clr = 1'b1;
                            oe_n   = 1'b0;
                            st_n   = ST_MACK;
                        end else begin
                            sh_tx = 1'b1;
                            oe_n  = ~sh_data[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            rd_req  = 1'b1;
                            ctr_inc = 1'b1;
                        end else begin
                            st_n = ST_SKIP;
                        end
                    end else if (scl_fall) begin
                        st_n = ST_TX;
                        oe_n = ~sh_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    // state register and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            hi_q    <= '0;
            rd_mode <= 1'b0;
            re_d    <= 1'b0;
        end else begin
            st   <= st_n;
            re_d <= mem_re;
            if (hi_cap)   hi_q    <= sh_data;
            if (mode_cap) rd_mode <= sh_data[0];
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            mem_re    <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            sda_oe <= oe_n;
            mem_re <= rd_req;
            mem_we <= wr_req;
            if (rd_req || wr_req) mem_addr <= ctr;
            if (wr_req)           mem_wdata <= sh_data;
        end
    end

    // R11: drive changes only follow an SCL-low sample
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_s));

    // R3: a non-addressed device stays off the line
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe);

    // R4: loading the counter never stores data
    a_r4_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_load |=> !mem_we);

    // R8: memory port carries one access at a time
    a_r8_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we}));

    // R2: STOP leaves the line released
    a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_oe);
endmodule

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [12:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int ref_ctr = 0;
    logic [7:0] ref_mem [int];
    logic [7:0] bmem [int];
    int r11_bad = 0;
    int r3_bad = 0;
    bit mm_window = 0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    i2c_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] mval(int a);
        return ref_mem.exists(a) ? ref_mem[a] : pat(a);
    endfunction

    // environment memory
    always @(posedge clk) begin
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : pat(int'(mem_addr));
    end

    // per-clock comparison against the line rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe && scl_m) r11_bad++;
            if (mm_window && sda_oe) r3_bad++;
        end
        prev_oe = sda_oe;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
    endtask

    task automatic put_bit(bit b);
        sda_m = b; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1; tick(Q); scl_m = 1; tick(Q / 2); b = sda_bus; tick(Q / 2); scl_m = 0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic cur_read(int n, string req);
        bit ack;
        logic [7:0] v;
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        check(ack, {req, " read address ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k < n - 1);
            check(v == mval(ref_ctr), req, v, mval(ref_ctr));
            ref_ctr = (ref_ctr + 1) % 8192;
        end
        i2c_stop();
        check(sda_oe == 1'b0, {req, " released after stop"}, sda_oe, 0);
    endtask

    task automatic set_addr(int hi, int lo, string req);
        bit ack;
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        check(ack, {req, " device ack"}, ack, 1);
        send_byte(8'(hi), ack);
        check(ack, {req, " high byte ack"}, ack, 1);
        send_byte(8'(lo), ack);
        check(ack, {req, " low byte ack"}, ack, 1);
        ref_ctr = ((hi << 8) | lo) & 8191;
    endtask

    task automatic write1(int hi, int lo, logic [7:0] d);
        bit ack;
        set_addr(hi, lo, "R10");
        send_byte(d, ack);
        check(ack, "R10 data ack", ack, 1);
        ref_mem[ref_ctr] = d;
        ref_ctr = (ref_ctr + 1) % 8192;
        i2c_stop();
    endtask

    task automatic run_all();
        bit ack;
        rst_n = 0;
        tick(5);
        rst_n = 1;
        tick(5);
        // R1: reset state
        check(sda_oe == 0 && mem_re == 0 && mem_we == 0, "R1 reset outputs", {sda_oe, mem_re, mem_we}, 0);
        cur_read(1, "R1 first read at 0");
        // R10, R7: write then current-address read continues past it
        write1(8'h00, 8'h10, 8'hA5);
        cur_read(1, "R7 next after write");
        // R6: random read back of the written byte
        set_addr(8'h00, 8'h10, "R6");
        cur_read(1, "R6 random read");
        // R5, R4: masked high bits, dummy write leaves data untouched
        set_addr(8'hE1, 8'h23, "R5");
        check(ref_ctr == 12'h123, "R5 masked address", ref_ctr, 12'h123);
        cur_read(1, "R5 R4 masked random read");
        // R3: wrong device address
        i2c_start();
        mm_window = 1;
        send_byte({7'h51, 1'b0}, ack);
        check(!ack, "R3 mismatch no ack", ack, 0);
        send_byte(8'h00, ack);
        check(!ack, "R3 ignored byte", ack, 0);
        send_byte(8'h10, ack);
        mm_window = 0;
        i2c_stop();
        check(r3_bad == 0, "R3 line untouched", r3_bad, 0);
        cur_read(1, "R3 counter kept");
        // R2, R4: STOP before the low byte keeps the counter
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h05, ack);
        i2c_stop();
        cur_read(1, "R2 abort keeps counter");
        // R8: sequential read ends with NOACK
        set_addr(8'h02, 8'h40, "R8");
        cur_read(4, "R8 sequential");
        cur_read(1, "R7 after stream");
        // R9: wrap at the top of the array
        set_addr(8'h1F, 8'hFE, "R9");
        cur_read(4, "R9 wrap stream");
        check(ref_ctr == 2, "R9 counter after wrap", ref_ctr, 2);
        cur_read(1, "R9 continue after wrap");
        // R11: drive changes only while SCL low, compared every clock
        check(r11_bad == 0, "R11 drive timing", r11_bad, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule